// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It derives a slow converter clock from the system clock with a programmable divider. When software sets the start bit, it waits three converter cycles, raises busy, and runs a fixed frame of 32 converter cycles. The frame opens with a sampling window, followed by a most-significant-bit-first binary search. The search drives a trial code to the capacitor array and reads back a single comparator bit. At the end of the frame the result is stored together with the channel it was taken from, busy drops, and an interrupt and a DMA request each pulse for one system clock.

Software reaches the block through a small word-wide register window with four addresses: control, data (read-only), divider, and analog setup. The block has two run modes. In single-shot mode it converts once and clears the start bit itself. In continuous mode it chains frames for as long as start stays set. A long-sample option moves cycles from comparator settling to sampling, and the frame still lasts 32 cycles. A status mask in the analog setup register hides the busy and channel bits of the data word. No start request is accepted unless both analog power-up bits are set.

Top module: `sar_conv_sequencer`

## Requirements
- R1: The divider (address 2, bits 14:0) gives one converter cycle every (divider + 1) system clocks. It resets to 7FFFh. Bit 15 of address 2 always reads 0.
- R2: In single-shot mode, busy (data bit 15) reads 1 for exactly 32 × (divider + 1) system clocks per conversion.
- R3: Busy first reads 1 after the 3 × (divider + 1) + 1-th clock edge that follows the edge storing a start bit of 1 (control bit 15).
- R4: When control bit 10 is 1 (single-shot), the block converts once and clears control bit 15 on the edge where busy drops. No further conversion starts until software writes start = 1 again.
- R5: When control bit 10 is 0 (continuous), frames follow back to back every 32 × (divider + 1) clocks with busy held at 1. After start is cleared, the frame in progress completes and then busy drops.
- R6: The data word (address 1) holds busy in bit 15, the channel tag in bits 14:12, zeros in bits 11:10 and the result in bits 9:0. It resets to 7000h.
- R7: The channel code is control bits 14:12. During a frame, `ch_en` is one-hot for codes 0 to 5 and all zero for codes 6 and 7. It is all zero outside frames.
- R8: When analog-setup bit 2 (address 3) is 1, data bits 15:12 read as 0. Bits 9:0 are unaffected.
- R9: Control bit 11 selects long sampling. `sample_en` is high for 12 × (divider + 1) clocks of the frame when the bit is 1, and for 4 × (divider + 1) clocks when it is 0. The frame length is the same in both cases.
- R10: `conv_irq` and `dma_req` each pulse high for one clock on the edge where a frame completes, and at no other time.
- R11: Each result bit, from bit 9 down to bit 0, is kept when `cmp_in` reads 1 while `trial_code` carries that bit as the trial. A comparator giving 1 for trial ≤ V therefore yields the result V.
- R12: Conversions need analog-setup bits 0 and 1 both set. If either bit is clear, a start bit is stored as 0 and busy stays low. A running frame is abandoned, with busy low one clock later and no interrupt.
- R13: Control resets to 0000h. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 data, 2 divider, 3 analog setup) |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr`, combinational |
| cmp_in | input | 1 | Comparator decision for the present trial code |
| trial_code | output | 10 | Code presented to the capacitor array |
| sample_en | output | 1 | High during the sampling window |
| ch_en | output | 6 | One-hot analog input select during a frame |
| conv_irq | output | 1 | Conversion-complete interrupt pulse |
| dma_req | output | 1 | DMA event pulse at each completed conversion |

## Verification
The assertions assume three things about the inputs. The divider and the long-sample bit are not rewritten while a frame is running. The comparator input is settled at each converter-cycle edge. The analog setup is not toggled on back-to-back clocks. The bench follows these rules by writing divider and mode only while busy is low. It derives `cmp_in` combinationally from `trial_code` and a held analog value, and it changes that value only at an interrupt, which falls well before the next search window opens.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W      = 10;
    localparam int CH_W       = 3;
    localparam int DIV_W      = 15;
    localparam int WORD_W     = 16;
    localparam int NUM_IN     = 6;
    localparam int FRAME_LEN  = 32;
    localparam int ARM_TICKS  = 3;
    localparam int SAMP_NORM  = 4;
    localparam int SAMP_LONG  = 12;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int BIT_W      = $clog2(RES_W);

    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_CONV} seq_state_e;

    typedef enum logic [1:0] {A_CTRL = 2'd0, A_DATA = 2'd1, A_DIV = 2'd2, A_ACFG = 2'd3} reg_addr_e;

    typedef struct packed {
        logic            start;
        logic [CH_W-1:0] ch;
        logic            long_samp;
        logic            single;
    } ctrl_t;

    typedef struct packed {
        logic stat_mask;
        logic ana_on;
        logic bias_on;
    } acfg_t;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] code;
    } result_t;

    typedef struct packed {
        logic             hit;
        logic [BIT_W-1:0] pos;
    } slot_t;

    // Map a frame index to the result bit under trial, if any.
    function automatic slot_t decode_slot(input logic [IDX_W-1:0] idx, input logic long_mode);
        int    s;
        int    rel;
        slot_t r;
        s     = long_mode ? SAMP_LONG : SAMP_NORM;
        rel   = int'(idx) - s;
        r.hit = (rel >= 0) && (rel < RES_W);
        r.pos = r.hit ? BIT_W'(RES_W - 1 - rel) : '0;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_data(input logic busy, input result_t r, input logic mask);
        logic [WORD_W-1:0] w;
        w = {busy, r.ch, 2'b00, r.code};
        if (mask) w[WORD_W-1 -: 4] = 4'b0000;
        return w;
    endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Phase restarts whenever the sequencer is idle.
    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/sar_reg_file.sv
module sar_reg_file import sar_seq_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              clr_start,
    input  logic              busy,
    input  result_t           res,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div,
    output logic              pwr_ok,
    output logic              stat_mask
);
    ctrl_t            ctrl_q;
    acfg_t            acfg_q;
    logic [DIV_W-1:0] div_q;

    assign pwr_ok    = acfg_q.bias_on & acfg_q.ana_on;
    assign stat_mask = acfg_q.stat_mask;
    assign ctrl      = ctrl_q;
    assign div       = div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            acfg_q <= '0;
            div_q  <= '1;
        end else begin
            if (clr_start) ctrl_q.start <= 1'b0;
            if (wr_en) begin
                case (reg_addr_e'(addr))
                    A_CTRL: begin
                        ctrl_q.start     <= wdata[15] & pwr_ok;
                        ctrl_q.ch        <= wdata[14:12];
                        ctrl_q.long_samp <= wdata[11];
                        ctrl_q.single    <= wdata[10];
                    end
                    A_DIV:  div_q  <= wdata[DIV_W-1:0];
                    A_ACFG: acfg_q <= wdata[2:0];
                    default: ;
                endcase
            end
            if (!pwr_ok) ctrl_q.start <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_CTRL:  rdata = {ctrl_q, 10'b0};
            A_DATA:  rdata = pack_data(busy, res, acfg_q.stat_mask);
            A_DIV:   rdata = {1'b0, div_q};
            default: rdata = {13'b0, acfg_q};
        endcase
    end

    assert_start_gated_R12: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !ctrl_q.start);

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq import sar_seq_pkg::*; #(
    parameter int ARM_TICKS_P = ARM_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pwr_ok,
    input  ctrl_t             ctrl,
    input  logic              cmp_in,
    output logic              run,
    output logic              busy,
    output logic              sample_en,
    output logic [RES_W-1:0]  trial_code,
    output logic [NUM_IN-1:0] ch_en,
    output logic              done,
    output logic              clr_start,
    output result_t           res
);
    localparam int AW   = $clog2(ARM_TICKS_P);
    localparam int LAST = FRAME_LEN - 1;

    seq_state_e       state_q;
    logic [AW-1:0]    arm_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] acc_q;
    logic [CH_W-1:0]  tag_q;
    logic             busy_q;
    logic             done_q;
    result_t          res_q;
    slot_t            slot;
    logic             in_conv;
    logic             frame_end;

    assign in_conv   = (state_q == ST_CONV);
    assign slot      = decode_slot(idx_q, ctrl.long_samp);
    assign frame_end = in_conv && tick && (idx_q == IDX_W'(LAST)) && pwr_ok;
    assign clr_start = frame_end && ctrl.single;

    assign run        = (state_q != ST_IDLE);
    assign busy       = busy_q;
    assign done       = done_q;
    assign res        = res_q;
    assign sample_en  = in_conv && !slot.hit && (int'(idx_q) < (ctrl.long_samp ? SAMP_LONG : SAMP_NORM));
    assign trial_code = acc_q | ((in_conv && slot.hit) ? (RES_W'(1) << slot.pos) : '0);
    assign ch_en      = (in_conv && int'(tag_q) < NUM_IN) ? (NUM_IN'(1) << tag_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            arm_q   <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
            tag_q   <= '1;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '{ch: '1, code: '0};
        end else begin
            done_q <= 1'b0;
            if (!pwr_ok) begin
                state_q <= ST_IDLE;
                busy_q  <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: if (ctrl.start) begin
                        state_q <= ST_ARM;
                        arm_q   <= '0;
                    end
                    ST_ARM: if (tick) begin
                        if (arm_q == AW'(ARM_TICKS_P - 1)) begin
                            state_q <= ST_CONV;
                            busy_q  <= 1'b1;
                            idx_q   <= '0;
                            acc_q   <= '0;
                            tag_q   <= ctrl.ch;
                        end else begin
                            arm_q <= arm_q + 1'b1;
                        end
                    end
                    ST_CONV: if (tick) begin
                        if (slot.hit) acc_q[slot.pos] <= cmp_in;
                        if (frame_end) begin
                            done_q     <= 1'b1;
                            res_q.code <= acc_q;
                            res_q.ch   <= tag_q;
                            if (ctrl.single || !ctrl.start) begin
                                state_q <= ST_IDLE;
                                busy_q  <= 1'b0;
                            end else begin
                                idx_q <= '0;
                                acc_q <= '0;
                                tag_q <= ctrl.ch;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assert_onehot_sel_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_en));

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && $past(pwr_ok)) |-> done_q);

    assert_power_off_R12: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !busy_q);

    assert_sample_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy_q);

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer import sar_seq_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  trial_code,
    output logic              sample_en,
    output logic [NUM_IN-1:0] ch_en,
    output logic              conv_irq,
    output logic              dma_req
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    logic             pwr_ok;
    logic             stat_mask;
    logic             run;
    logic             tick;
    logic             busy;
    logic             done;
    logic             clr_start;
    result_t          res;

    sar_reg_file u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .clr_start (clr_start),
        .busy      (busy),
        .res       (res),
        .ctrl      (ctrl),
        .div       (div),
        .pwr_ok    (pwr_ok),
        .stat_mask (stat_mask)
    );

    sar_clk_div #(.DW(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div),
        .tick (tick)
    );

    sar_frame_seq #(.ARM_TICKS_P(ARM_TICKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pwr_ok     (pwr_ok),
        .ctrl       (ctrl),
        .cmp_in     (cmp_in),
        .run        (run),
        .busy       (busy),
        .sample_en  (sample_en),
        .trial_code (trial_code),
        .ch_en      (ch_en),
        .done       (done),
        .clr_start  (clr_start),
        .res        (res)
    );

    assign conv_irq = done;
    assign dma_req  = done;

    assert_mask_hides_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_mask && addr == 2'd1) |-> (rdata[15:12] == 4'b0000));

endmodule

// File: tb/sim_sar_conv_sequencer.sv
module sim_sar_conv_sequencer;
    localparam int CLK_P = 10;
    localparam int LIM   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        cmp_in;
    logic [9:0]  trial_code;
    logic        sample_en;
    logic [5:0]  ch_en;
    logic        conv_irq;
    logic        dma_req;
    logic [9:0]  vin = 10'h0;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    assign cmp_in = (trial_code <= vin);

    always @(negedge clk) begin
        cyc++;
        if (conv_irq) irq_cnt++;
    end

    sar_conv_sequencer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cmp_in(cmp_in), .trial_code(trial_code), .sample_en(sample_en), .ch_en(ch_en),
        .conv_irq(conv_irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_single(input logic [2:0] ch, input logic lng, input logic [9:0] v, input int d);
        int n;
        int m;
        int s;
        logic [15:0] r;
        vin = v;
        wr(2'd2, 16'(d));
        wr(2'd0, {1'b1, ch, lng, 1'b1, 10'b0});
        addr = 2'd1;
        #1;
        n = 0;
        while (!rdata[15] && n < LIM) begin @(negedge clk); #1; n++; end
        chk("R3 busy rise delay", n, 3*(d+1)+1);
        chk("R7 channel select", ch_en, (ch < 6) ? (6'd1 << ch) : 6'd0);
        m = 0; s = 0;
        while (rdata[15] && m < LIM) begin
            if (sample_en) s++;
            @(negedge clk); #1; m++;
        end
        chk("R2 busy length", m, 32*(d+1));
        chk("R9 sample window", s, (lng ? 12 : 4)*(d+1));
        chk("R10 irq at end", {conv_irq, dma_req}, 2'b11);
        chk("R11 R6 data word", rdata, {1'b0, ch, 2'b00, v});
        @(negedge clk);
        chk("R10 irq one clock", {conv_irq, dma_req}, 2'b00);
        rd(2'd0, r);
        chk("R4 start cleared", r[15], 1'b0);
    endtask

    initial begin
        #(CLK_P*200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int i0;
        int t0;
        logic [9:0] vals [4];
        vals[0] = 10'h155; vals[1] = 10'h2AA; vals[2] = 10'h000; vals[3] = 10'h3FF;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Reset state
        rd(2'd0, r); chk("R13 ctrl reset", r, 16'h0000);
        rd(2'd1, r); chk("R6 data reset", r, 16'h7000);
        rd(2'd2, r); chk("R1 divider reset", r, 16'h7FFF);
        rd(2'd3, r); chk("R12 setup reset", r, 16'h0000);
        chk("R10 irq idle", {conv_irq, dma_req}, 2'b00);

        // Divider bit 15 ignored, data writes ignored
        wr(2'd2, 16'hFFFF); rd(2'd2, r); chk("R1 div bit15", r, 16'h7FFF);
        wr(2'd1, 16'hABCD); rd(2'd1, r); chk("R13 data write ignored", r, 16'h7000);

        // Unpowered start is ignored
        wr(2'd3, 16'h0001);
        i0 = irq_cnt;
        wr(2'd0, 16'h9400);
        rd(2'd0, r); chk("R12 start refused", r[15], 1'b0);
        idle(80);
        rd(2'd1, r); chk("R12 busy low unpowered", r[15], 1'b0);
        chk("R12 no irq unpowered", irq_cnt - i0, 0);

        wr(2'd3, 16'h0003);

        // Timing across dividers, both sample modes
        run_single(3'd2, 1'b0, 10'h1A5, 2);
        run_single(3'd5, 1'b1, 10'h2F0, 1);
        run_single(3'd6, 1'b0, 10'h3FF, 5);
        run_single(3'd0, 1'b1, 10'h000, 3);

        // Single-shot does not rearm
        i0 = irq_cnt;
        addr = 2'd1;
        idle(100);
        #1 chk("R4 stays idle", {rdata[15], 26'(irq_cnt - i0)}, 27'd0);

        // Exhaustive code sweep at divide-by-one
        for (int c = 0; c < 1024; c++) begin
            run_single(3'(c % 8), c[4], 10'(c), 0);
        end

        // Continuous mode
        wr(2'd2, 16'd1);
        vin = vals[0];
        i0 = irq_cnt;
        wr(2'd0, {1'b1, 3'd4, 1'b0, 1'b0, 10'b0});
        addr = 2'd1;
        t0 = 0;
        for (int k = 0; k < 4; k++) begin
            int w;
            w = 0;
            do begin @(negedge clk); #1; w++; end while (!conv_irq && w < LIM);
            if (k > 0) chk("R5 frame spacing", cyc - t0, 64);
            t0 = cyc;
            addr = 2'd1;
            #1;
            if (k < 3) chk("R5 busy held", rdata, {1'b1, 3'd4, 2'b00, vals[k]});
            else       chk("R5 stops after clear", rdata, {1'b0, 3'd4, 2'b00, vals[k]});
            if (k < 3) vin = vals[k+1];
            if (k == 2) wr(2'd0, {1'b0, 3'd4, 1'b0, 1'b0, 10'b0});
        end
        i0 = irq_cnt;
        idle(200);
        chk("R5 no irq after stop", irq_cnt - i0, 0);

        // Status mask
        wr(2'd3, 16'h0007);
        wr(2'd2, 16'd0);
        vin = 10'h3C3;
        wr(2'd0, {1'b1, 3'd5, 1'b0, 1'b1, 10'b0});
        idle(12);
        rd(2'd1, r); chk("R8 mask during busy", r[15:12], 4'h0);
        idle(50);
        rd(2'd1, r); chk("R8 mask after", r, 16'h03C3);
        wr(2'd3, 16'h0003);
        rd(2'd1, r); chk("R8 unmasked", r, 16'h53C3);

        // Power drop mid-frame abandons the conversion
        vin = 10'h011;
        wr(2'd0, {1'b1, 3'd1, 1'b0, 1'b1, 10'b0});
        idle(15);
        rd(2'd1, r); chk("R12 busy before drop", r[15], 1'b1);
        i0 = irq_cnt;
        wr(2'd3, 16'h0002);
        idle(2);
        rd(2'd1, r); chk("R12 abandoned", r, 16'h53C3);
        idle(60);
        chk("R12 no irq after drop", irq_cnt - i0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule